// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a host register interface and the bit-level engine of an I2C master. The host issues one 9-bit command word per write. When the top bit is clear, the low byte is queued for transmission. When the top bit is set, the word is queued as a request for the engine to read one byte from the bus. The engine draws command words from the transmit queue through a valid/ready handshake. It delivers received bytes into the receive queue, which the host drains one byte per read strobe.

Both queue fill levels are visible at all times. Each level is compared with a host-programmed threshold to produce a "transmit running low" condition and a "receive has data" condition. A read request moves to the engine only when the receive queue holds a free slot that no earlier read request has claimed, so a received byte is never lost for lack of space. A transmit abort from the engine empties both queues and drops all outstanding claims. Writes to a full transmit queue, reads from an empty receive queue and bytes that arrive at a full receive queue are each reported with a one-cycle pulse.

Top module: `i2c_xfer_fifo`

## Requirements
- R1: A host write with bit 8 clear queues the 9-bit word unchanged. Words reach `cmdData` in the order they were written, one per cycle in which `cmdValid` and `cmdReady` are both high.
- R2: A host write with bit 8 set (for example 0x100) queues a read request. The request appears on `cmdData` with bit 8 set, in its place in the write order.
- R3: A host write while `txLevel` equals TX_DEPTH is dropped. `txLevel` stays at TX_DEPTH and `txOverflow` is high for exactly the following cycle.
- R4: While the receive queue is not empty, `hostRdData` shows the oldest received byte, and `hostRdEn` removes it. Bytes come out in the order they arrived.
- R5: While the receive queue is empty, `hostRdData` is zero. A `hostRdEn` then changes no level and raises `rxUnderflow` for exactly the following cycle.
- R6: A byte offered on `engRxValid` while `rxLevel` equals RX_DEPTH is dropped. `rxLevel` stays at RX_DEPTH and `rxOverflow` is high for the following cycle.
- R7: `txLevel` and `rxLevel` give the number of entries held. Each changes in the cycle after the edge that accepted or removed an entry.
- R8: `txEmptyIrq` is high exactly while `txLevel` is less than or equal to `txThresh`.
- R9: `rxFullIrq` is high exactly while `rxLevel` is greater than `rxThresh`.
- R10: A read request at the head of the transmit queue is offered (`cmdValid`) only while `rxLevel` plus the count of issued but unanswered read requests is below RX_DEPTH. Each byte accepted from the engine releases one claim.
- R11: `abortFlush` empties both queues and clears all read claims by the next cycle. A host write or engine byte in the same cycle is discarded, and `cmdValid` is low during that cycle.
- R12: After reset both levels are zero, `cmdValid` is low and all three event pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host command write strobe |
| hostWrData | input | 9 | Command word; bit 8 set = read request |
| hostRdEn | input | 1 | Host receive read strobe |
| hostRdData | output | 8 | Oldest received byte, zero when empty |
| txThresh | input | $clog2(TX_DEPTH+1) | Transmit low-water threshold |
| rxThresh | input | $clog2(RX_DEPTH+1) | Receive threshold |
| txLevel | output | $clog2(TX_DEPTH+1) | Transmit queue entries |
| rxLevel | output | $clog2(RX_DEPTH+1) | Receive queue entries |
| txEmptyIrq | output | 1 | Transmit level at or below threshold |
| rxFullIrq | output | 1 | Receive level above threshold |
| txOverflow | output | 1 | Pulse: host write dropped |
| rxOverflow | output | 1 | Pulse: engine byte dropped |
| rxUnderflow | output | 1 | Pulse: read of empty receive queue |
| cmdValid | output | 1 | Head command offered to engine |
| cmdReady | input | 1 | Engine takes the head command |
| cmdData | output | 9 | Head command word |
| engRxValid | input | 1 | Engine delivers a received byte |
| engRxReady | output | 1 | Receive queue has room |
| engRxData | input | 8 | Received byte from engine |
| abortFlush | input | 1 | Transmit abort: flush both queues |

## Verification
The bench builds the block with both depths set to 4. At that size a few writes fill the transmit queue, so the drop path and its pulse are reached within a handful of cycles. Four read requests are enough to use up every receive slot, which makes the point where a read request is held back observable. The transmit threshold of 3 puts the boundary one entry below full. The receive threshold is moved from 0 to 2 while the queue drains, which exercises the comparison on both sides.

// File: rtl/i2c_xfer_fifo_pkg.sv
package i2c_xfer_fifo_pkg;
  localparam int CMD_W  = 9;
  localparam int BYTE_W = 8;
  localparam int RD_BIT = 8;

  // Strobes from control to datapath.
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } fifoStrobes_t;
endpackage

// File: rtl/i2c_xfer_fifo_ring.sv
module i2c_xfer_fifo_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

  // R3: control never pushes into a full ring
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < LVL_W'(DEPTH)));
  // R5: control never pops an empty ring
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level != '0));
  // R11: a flush leaves the ring empty
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
endmodule

// File: rtl/i2c_xfer_fifo_dp.sv
module i2c_xfer_fifo_dp
  import i2c_xfer_fifo_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TXLW = $clog2(TX_DEPTH + 1),
  localparam int RXLW = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoStrobes_t      strb,
  input  logic [CMD_W-1:0]  hostWrData,
  input  logic [BYTE_W-1:0] engRxData,
  output logic [CMD_W-1:0]  txHead,
  output logic [BYTE_W-1:0] rxHead,
  output logic [TXLW-1:0]   txLevel,
  output logic [RXLW-1:0]   rxLevel
);
  i2c_xfer_fifo_ring #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txRing (
    .clk(clk), .rst_n(rst_n),
    .push(strb.txPush), .pop(strb.txPop), .flush(strb.flush),
    .wrData(hostWrData), .rdData(txHead), .level(txLevel)
  );

  i2c_xfer_fifo_ring #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxRing (
    .clk(clk), .rst_n(rst_n),
    .push(strb.rxPush), .pop(strb.rxPop), .flush(strb.flush),
    .wrData(engRxData), .rdData(rxHead), .level(rxLevel)
  );
endmodule

// File: rtl/i2c_xfer_fifo_ctrl.sv
module i2c_xfer_fifo_ctrl
  import i2c_xfer_fifo_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TXLW = $clog2(TX_DEPTH + 1),
  localparam int RXLW = $clog2(RX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hostWrEn,
  input  logic            hostRdEn,
  input  logic            cmdReady,
  input  logic            engRxValid,
  input  logic            abortFlush,
  input  logic            headIsRead,
  input  logic [TXLW-1:0] txLevel,
  input  logic [RXLW-1:0] rxLevel,
  input  logic [TXLW-1:0] txThresh,
  input  logic [RXLW-1:0] rxThresh,
  output fifoStrobes_t    strb,
  output logic            cmdValid,
  output logic            engRxReady,
  output logic            txEmptyIrq,
  output logic            rxFullIrq,
  output logic            txOverflow,
  output logic            rxOverflow,
  output logic            rxUnderflow
);
  logic [RXLW-1:0] pendReads;
  logic [RXLW:0]   rsvSum;
  logic            txFull, rxFull, rxEmpty, reserveOk, readIssued, claimDone;

  assign txFull    = (txLevel == TXLW'(TX_DEPTH));
  assign rxFull    = (rxLevel == RXLW'(RX_DEPTH));
  assign rxEmpty   = (rxLevel == '0);
  assign rsvSum    = {1'b0, rxLevel} + {1'b0, pendReads};
  assign reserveOk = rsvSum < (RXLW + 1)'(RX_DEPTH);

  assign cmdValid   = (txLevel != '0) && !abortFlush && (!headIsRead || reserveOk);
  assign engRxReady = !rxFull;

  always_comb begin
    strb        = '0;
    strb.flush  = abortFlush;
    strb.txPush = hostWrEn && !txFull && !abortFlush;
    strb.txPop  = cmdValid && cmdReady;
    strb.rxPush = engRxValid && !rxFull && !abortFlush;
    strb.rxPop  = hostRdEn && !rxEmpty && !abortFlush;
  end

  assign readIssued = strb.txPop && headIsRead;
  assign claimDone  = strb.rxPush && ((pendReads != '0) || readIssued);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendReads <= '0;
    end else if (abortFlush) begin
      pendReads <= '0;
    end else begin
      pendReads <= pendReads + RXLW'(readIssued) - RXLW'(claimDone);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txOverflow  <= 1'b0;
      rxOverflow  <= 1'b0;
      rxUnderflow <= 1'b0;
    end else begin
      txOverflow  <= hostWrEn && txFull && !abortFlush;
      rxOverflow  <= engRxValid && rxFull && !abortFlush;
      rxUnderflow <= hostRdEn && rxEmpty;
    end
  end

  assign txEmptyIrq = (txLevel <= txThresh);
  assign rxFullIrq  = (rxLevel > rxThresh);

  // R10: received bytes plus outstanding claims never exceed receive capacity
  p_reserve_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsvSum <= (RXLW + 1)'(RX_DEPTH));
  // R3: a dropped write leaves the full transmit level intact
  p_tx_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrEn && txFull && !abortFlush && !(cmdValid && cmdReady)) |=> (txLevel == TXLW'(TX_DEPTH)));
  // R6: a dropped byte leaves the full receive level intact
  p_rx_drop_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (engRxValid && rxFull && !abortFlush && !hostRdEn) |=> (rxLevel == RXLW'(RX_DEPTH)));
endmodule

// File: rtl/i2c_xfer_fifo.sv
module i2c_xfer_fifo
  import i2c_xfer_fifo_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TXLW = $clog2(TX_DEPTH + 1),
  localparam int RXLW = $clog2(RX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hostWrEn,
  input  logic [8:0]      hostWrData,
  input  logic            hostRdEn,
  output logic [7:0]      hostRdData,
  input  logic [TXLW-1:0] txThresh,
  input  logic [RXLW-1:0] rxThresh,
  output logic [TXLW-1:0] txLevel,
  output logic [RXLW-1:0] rxLevel,
  output logic            txEmptyIrq,
  output logic            rxFullIrq,
  output logic            txOverflow,
  output logic            rxOverflow,
  output logic            rxUnderflow,
  output logic            cmdValid,
  input  logic            cmdReady,
  output logic [8:0]      cmdData,
  input  logic            engRxValid,
  output logic            engRxReady,
  input  logic [7:0]      engRxData,
  input  logic            abortFlush
);
  fifoStrobes_t      strb;
  logic [CMD_W-1:0]  txHead;
  logic [BYTE_W-1:0] rxHead;

  i2c_xfer_fifo_ctrl #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .cmdReady(cmdReady),
    .engRxValid(engRxValid), .abortFlush(abortFlush),
    .headIsRead(txHead[RD_BIT]),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .strb(strb), .cmdValid(cmdValid), .engRxReady(engRxReady),
    .txEmptyIrq(txEmptyIrq), .rxFullIrq(rxFullIrq),
    .txOverflow(txOverflow), .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow)
  );

  i2c_xfer_fifo_dp #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .hostWrData(hostWrData), .engRxData(engRxData),
    .txHead(txHead), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel)
  );

  assign cmdData    = txHead;
  assign hostRdData = (rxLevel != '0) ? rxHead : '0;
endmodule

// File: tb/i2c_xfer_fifo_tb.sv
module i2c_xfer_fifo_tb;
  localparam int TXD = 4;
  localparam int RXD = 4;
  localparam int TXLW = $clog2(TXD + 1);
  localparam int RXLW = $clog2(RXD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0, cmdReady = 1'b0, engRxValid = 1'b0, abortFlush = 1'b0;
  logic [8:0] hostWrData = '0;
  logic [7:0] engRxData = '0;
  logic [TXLW-1:0] txThresh = TXLW'(3);
  logic [RXLW-1:0] rxThresh = '0;
  logic [7:0] hostRdData;
  logic [TXLW-1:0] txLevel;
  logic [RXLW-1:0] rxLevel;
  logic txEmptyIrq, rxFullIrq, txOverflow, rxOverflow, rxUnderflow, cmdValid, engRxReady;
  logic [8:0] cmdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [8:0] expCmd[$];

  always #4 clk = ~clk;

  i2c_xfer_fifo #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .txThresh(txThresh), .rxThresh(rxThresh),
    .txLevel(txLevel), .rxLevel(rxLevel), .txEmptyIrq(txEmptyIrq), .rxFullIrq(rxFullIrq),
    .txOverflow(txOverflow), .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .engRxValid(engRxValid), .engRxReady(engRxReady), .engRxData(engRxData),
    .abortFlush(abortFlush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Every step starts at a falling edge; checks sample 1 ns later.
  task automatic stepTo();
    @(negedge clk); #1;
  endtask

  // Monitor: scoreboard for engine-side command handshakes (R1, R2)
  always begin
    @(negedge clk); #1;
    if (rst_n && cmdValid && cmdReady) begin
      if (expCmd.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1/R2: actual 0x%0h expected none", cmdData);
      end else begin
        chk("R1/R2 cmd order", 32'(cmdData), 32'(expCmd.pop_front()));
      end
    end
  end

  task automatic hostWrite(input logic [8:0] w, input bit expectKept);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = w;
    if (expectKept) expCmd.push_back(w);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk);
    engRxValid = 1'b1; engRxData = b;
    @(negedge clk);
    engRxValid = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] exp, input string req);
    @(negedge clk);
    hostRdEn = 1'b1;
    #1 chk(req, 32'(hostRdData), 32'(exp));
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 txLevel", 32'(txLevel), 0);
    chk("R12 rxLevel", 32'(rxLevel), 0);
    chk("R12 cmdValid", 32'(cmdValid), 0);
    chk("R12 pulses", 32'({txOverflow, rxOverflow, rxUnderflow}), 0);
    chk("R8 empty below thresh", 32'(txEmptyIrq), 1);
    chk("R9 rx none", 32'(rxFullIrq), 0);

    // Fill transmit queue with engine stalled
    hostWrite(9'h0A5, 1'b1);
    hostWrite(9'h15A, 1'b1);
    hostWrite(9'h03C, 1'b1);
    #1 chk("R8 level 3 at thresh 3", 32'(txEmptyIrq), 1);
    chk("R7 txLevel 3", 32'(txLevel), 3);
    hostWrite(9'h0FF, 1'b1);
    #1 chk("R7 txLevel full", 32'(txLevel), 4);
    chk("R8 level 4 above thresh", 32'(txEmptyIrq), 0);
    hostWrite(9'h011, 1'b0);
    #1 chk("R3 txOverflow pulse", 32'(txOverflow), 1);
    chk("R3 level held", 32'(txLevel), 4);
    stepTo();
    chk("R3 pulse one cycle", 32'(txOverflow), 0);

    // Drain to engine (R1, R2 via monitor)
    @(negedge clk); cmdReady = 1'b1;
    repeat (6) @(negedge clk);
    #1 chk("R7 txLevel drained", 32'(txLevel), 0);

    // R10: one claim outstanding; four more read requests, only three fit
    hostWrite(9'h100, 1'b1);
    hostWrite(9'h100, 1'b1);
    hostWrite(9'h100, 1'b1);
    hostWrite(9'h100, 1'b1);
    repeat (3) @(negedge clk);
    #1 chk("R10 blocked level", 32'(txLevel), 1);
    chk("R10 blocked valid", 32'(cmdValid), 0);
    engPush(8'h77);
    #1 chk("R10 still blocked", 32'(cmdValid), 0);
    chk("R7 rxLevel 1", 32'(rxLevel), 1);
    hostRead(8'h77, "R4 first byte");
    repeat (2) @(negedge clk);
    #1 chk("R10 released", 32'(txLevel), 0);

    // R6, R9, R4
    engPush(8'h01);
    engPush(8'h02);
    engPush(8'h03);
    engPush(8'h04);
    #1 chk("R7 rxLevel full", 32'(rxLevel), 4);
    chk("R9 above thresh 0", 32'(rxFullIrq), 1);
    chk("R6 engRxReady low", 32'(engRxReady), 0);
    engPush(8'h05);
    #1 chk("R6 rxOverflow pulse", 32'(rxOverflow), 1);
    chk("R6 level held", 32'(rxLevel), 4);
    rxThresh = RXLW'(2);
    hostRead(8'h01, "R4 order 1");
    #1 chk("R9 level 3 thresh 2", 32'(rxFullIrq), 1);
    hostRead(8'h02, "R4 order 2");
    #1 chk("R9 level 2 thresh 2", 32'(rxFullIrq), 0);
    hostRead(8'h03, "R4 order 3");
    hostRead(8'h04, "R4 order 4");

    // R5 underflow
    hostRead(8'h00, "R5 empty reads zero");
    #1 chk("R5 rxUnderflow pulse", 32'(rxUnderflow), 1);
    chk("R5 level unchanged", 32'(rxLevel), 0);

    // R11 abort: leave two claims outstanding, then fill both queues
    hostWrite(9'h100, 1'b1);
    hostWrite(9'h100, 1'b1);
    repeat (2) @(negedge clk);
    cmdReady = 1'b0;
    hostWrite(9'h021, 1'b0);
    hostWrite(9'h022, 1'b0);
    hostWrite(9'h023, 1'b0);
    engPush(8'hA1);
    #1 chk("R7 pre-abort tx", 32'(txLevel), 3);
    chk("R7 pre-abort rx", 32'(rxLevel), 1);
    @(negedge clk);
    abortFlush = 1'b1; hostWrEn = 1'b1; hostWrData = 9'h0EE;
    engRxValid = 1'b1; engRxData = 8'hB2;
    #1 chk("R11 valid low in abort", 32'(cmdValid), 0);
    @(negedge clk);
    abortFlush = 1'b0; hostWrEn = 1'b0; engRxValid = 1'b0;
    #1 chk("R11 tx flushed", 32'(txLevel), 0);
    chk("R11 rx flushed", 32'(rxLevel), 0);
    expCmd.delete();
    @(negedge clk); cmdReady = 1'b1;
    hostWrite(9'h100, 1'b1);
    hostWrite(9'h100, 1'b1);
    hostWrite(9'h100, 1'b1);
    hostWrite(9'h100, 1'b1);
    repeat (3) @(negedge clk);
    #1 chk("R11 claims cleared", 32'(txLevel), 0);
    chk("R1 scoreboard drained", 32'(expCmd.size()), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule